// File: doc/BRIEF.md
# Serial Transmitter with Clear-to-Send Flow Control

This block is the sending half of a serial port. It runs in one of two modes. In asynchronous mode it builds character frames and times each bit from a divide-by-16 prescaler that counts a shared serial base-clock enable. In shift mode it sends one byte with no framing. Each bit is clocked either by an internally generated shift clock, which is driven out, or by an external clock input. That input is synchronised, and the edge it shifts on is selectable.

The CPU writes a single-entry holding buffer. The engine takes the word from the buffer at its next bit step, so a word written during a frame goes out directly after that frame's stop bit. An optional flow-control input acts only at frame boundaries. Raising it never cuts a frame short. It stops the next frame from starting, and if the buffer is empty at that point the block asks the CPU for data.

Top module: `ser_tx_top`

## Requirements
- R1: Reset state: `txd_o` is 1, `sclk_o` is 0, `tx_irq_o` is 0 and `buf_empty_o` is 1.
- R2: In asynchronous mode (`io_mode_i`=0), each bit holds `txd_o` for exactly 16 cycles in which `base_en_i` is 1. A bit step occurs on the 16th, 32nd, … enable after reset.
- R3: In asynchronous mode, a written word starts its frame (`txd_o` falls) at the first bit step after the write cycle, never before it.
- R4: A frame is a low start bit, then data bits LSB first, then one high stop bit. `fmt_i`=0 sends 7 data bits, 1 sends 8, 2 sends 8 plus a parity bit, and 3 sends 9. `txd_o` is 1 when idle.
- R5: With `fmt_i`=2, the bit after data bit 7 is even parity over `wr_data_i[7:0]`.
- R6: A write makes `buf_empty_o` 0 on the next cycle. The flag returns to 1 when the engine takes the word. A word written during a frame starts on the bit step that ends the stop bit, with no idle gap.
- R7: With `hs_en_i`=1 and `cts_i`=1, a frame in progress completes, and no new frame starts. The held word starts at the first bit step after `cts_i` returns to 0.
- R8: With `hs_en_i`=0, `cts_i` has no effect on when frames start.
- R9: `tx_irq_o` pulses for one cycle when the engine takes a word from the buffer. It also pulses when a frame ends while flow control holds transmission and the buffer is empty.
- R10: In shift mode with the internal clock (`io_mode_i`=1, `ext_sel_i`=0), 8 bits go out LSB first. `sclk_o` rises once per bit, in the same cycle that the bit appears. It makes exactly 8 rises per byte and is 0 otherwise. `sclk_o` is 0 in every other mode.
- R11: In shift mode with the external clock (`ext_sel_i`=1), `ext_clk_i` passes through a two-flop synchroniser. `ext_fall_i`=0 shifts on rising edges and 1 shifts on falling edges, and the other edge is ignored. The 9th selected edge returns `txd_o` to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| base_en_i | input | 1 | Serial base-clock enable |
| wr_en_i | input | 1 | CPU write strobe for the holding buffer |
| wr_data_i | input | 9 | Word to transmit |
| io_mode_i | input | 1 | 0 asynchronous, 1 shift mode |
| fmt_i | input | 2 | Asynchronous data format (see R4) |
| hs_en_i | input | 1 | Enables flow control by `cts_i` |
| cts_i | input | 1 | Clear-to-send, 1 holds transmission |
| ext_sel_i | input | 1 | Shift mode: 1 uses `ext_clk_i` |
| ext_clk_i | input | 1 | External shift clock (asynchronous) |
| ext_fall_i | input | 1 | External edge select, 1 for falling |
| txd_o | output | 1 | Serial data out |
| sclk_o | output | 1 | Internal shift clock out |
| tx_irq_o | output | 1 | Transmit interrupt pulse |
| buf_empty_o | output | 1 | Holding buffer is empty |

## Verification
The bench sweeps every format over data words with both edge patterns and checks each bit at its first and its last cycle. A prescaler off by one count therefore fails in the first frame, and a reversed or misplaced parity bit shows up as a wrong bit. It writes a second word during a frame and requires the new start bit in the cycle right after the stop bit; a design that idles for a bit period between frames fails that check. It raises flow control mid-frame and requires the whole frame, a stall interrupt, and a silent line until release. A design that cut the frame, forgot the interrupt or ignored the release timing would differ there. In shift mode it counts clock rises per byte, and it drives both external edges while only the selected one may move the data.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;
  typedef enum logic [1:0] {
    FMT_D7  = 2'd0,
    FMT_D8  = 2'd1,
    FMT_D8P = 2'd2,
    FMT_D9  = 2'd3
  } tx_fmt_e;
endpackage

// File: rtl/ser_tx_div.sv
module ser_tx_div #(
  parameter int DIV_W = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o,
  output logic mid_o,
  output logic msb_o
);
  localparam logic [DIV_W-1:0] CNT_MAX = '1;
  localparam logic [DIV_W-1:0] MID_M1  = DIV_W'((1 << (DIV_W - 1)) - 1);

  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (en_i) cnt_q <= cnt_q + DIV_W'(1);
  end

  assign tick_o = en_i && (cnt_q == CNT_MAX);
  assign mid_o  = en_i && (cnt_q == MID_M1);
  assign msb_o  = cnt_q[DIV_W-1];
endmodule

// File: rtl/ser_tx_edge.sv
module ser_tx_edge #(
  parameter int SYNC_N = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clk_in_i,
  input  logic fall_sel_i,
  output logic edge_o
);
  logic [SYNC_N:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[SYNC_N-1:0], clk_in_i};
  end

  // sr_q[SYNC_N-1] is the synchronised level, sr_q[SYNC_N] its previous value
  assign edge_o = fall_sel_i ? (!sr_q[SYNC_N-1] &&  sr_q[SYNC_N])
                             : ( sr_q[SYNC_N-1] && !sr_q[SYNC_N]);
endmodule

// File: rtl/ser_tx_shift.sv
module ser_tx_shift
  import ser_tx_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int IO_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              go_i,
  input  logic              io_mode_i,
  input  tx_fmt_e           fmt_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              busy_o,
  output logic              txd_o,
  output logic              load_o,
  output logic              end_o
);
  localparam int FRAME_W = DATA_W + 3;
  localparam int LEN_W   = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] sh_q, vec;
  logic [LEN_W-1:0]   left_q, len;
  logic               busy_q, last;
  int                 nd;

  always_comb begin
    vec = '1;
    nd  = DATA_W - 1;
    if (io_mode_i) begin
      for (int i = 0; i < IO_W; i++) vec[i] = data_i[i];
      len = LEN_W'(IO_W);
    end else begin
      unique case (fmt_i)
        FMT_D7:  nd = DATA_W - 2;
        FMT_D9:  nd = DATA_W;
        default: nd = DATA_W - 1;
      endcase
      vec[0] = 1'b0;
      for (int i = 0; i < DATA_W; i++)
        if (i < nd) vec[i+1] = data_i[i];
      if (fmt_i == FMT_D8P) vec[DATA_W] = ^data_i[DATA_W-2:0];
      len = LEN_W'(nd + 2 + ((fmt_i == FMT_D8P) ? 1 : 0));
    end
  end

  assign last   = (left_q == LEN_W'(1));
  assign load_o = step_i && go_i && (!busy_q || last);
  assign end_o  = step_i && busy_q && last && !go_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '1;
      left_q <= '0;
      busy_q <= 1'b0;
    end else if (step_i) begin
      if (busy_q && !last) begin
        sh_q   <= {1'b1, sh_q[FRAME_W-1:1]};
        left_q <= left_q - LEN_W'(1);
      end else if (go_i) begin
        sh_q   <= vec;
        left_q <= len;
        busy_q <= 1'b1;
      end else begin
        busy_q <= 1'b0;
      end
    end
  end

  assign busy_o = busy_q;
  assign txd_o  = busy_q ? sh_q[0] : 1'b1;
endmodule

// File: rtl/ser_tx_top.sv
module ser_tx_top
  import ser_tx_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int DIV_W  = 4,
  parameter int SYNC_N = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              base_en_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              io_mode_i,
  input  logic [1:0]        fmt_i,
  input  logic              hs_en_i,
  input  logic              cts_i,
  input  logic              ext_sel_i,
  input  logic              ext_clk_i,
  input  logic              ext_fall_i,
  output logic              txd_o,
  output logic              sclk_o,
  output logic              tx_irq_o,
  output logic              buf_empty_o
);
  logic              bit_tick, mid_tick, div_msb, ext_edge;
  logic              step, hold, go, busy, load, fin;
  logic              full_q, irq_q;
  logic [DATA_W-1:0] buf_q;

  ser_tx_div #(.DIV_W(DIV_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (base_en_i),
    .tick_o (bit_tick),
    .mid_o  (mid_tick),
    .msb_o  (div_msb)
  );

  ser_tx_edge #(.SYNC_N(SYNC_N)) u_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clk_in_i   (ext_clk_i),
    .fall_sel_i (ext_fall_i),
    .edge_o     (ext_edge)
  );

  assign step = io_mode_i ? (ext_sel_i ? ext_edge : mid_tick) : bit_tick;
  assign hold = hs_en_i && cts_i;
  assign go   = full_q && !hold;

  ser_tx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .step_i    (step),
    .go_i      (go),
    .io_mode_i (io_mode_i),
    .fmt_i     (tx_fmt_e'(fmt_i)),
    .data_i    (buf_q),
    .busy_o    (busy),
    .txd_o     (txd_o),
    .load_o    (load),
    .end_o     (fin)
  );

  // a write in the handoff cycle refills the buffer behind the loaded word
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q  <= '0;
      full_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (wr_en_i) begin
        buf_q  <= wr_data_i;
        full_q <= 1'b1;
      end else if (load) begin
        full_q <= 1'b0;
      end
      irq_q <= load || (fin && hold && !full_q);
    end
  end

  assign sclk_o      = io_mode_i && !ext_sel_i && busy && div_msb;
  assign tx_irq_o    = irq_q;
  assign buf_empty_o = !full_q;
endmodule

module ser_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic io_mode_i,
  input logic ext_sel_i,
  input logic hs_en_i,
  input logic cts_i,
  input logic wr_en_i,
  input logic tick_i,
  input logic busy_i,
  input logic txd_o,
  input logic sclk_o,
  input logic tx_irq_o,
  input logic buf_empty_o
);
  p_bit_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!io_mode_i && $past(!io_mode_i) && !$past(tick_i)) |-> $stable(txd_o));

  p_wr_fills_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> !buf_empty_o);

  p_cts_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs_en_i && cts_i && !busy_i) |=> !busy_i);

  p_irq_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_irq_o |=> !tx_irq_o);

  p_sclk_mode_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> (io_mode_i && !ext_sel_i));
endmodule

bind ser_tx_top ser_tx_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .io_mode_i   (io_mode_i),
  .ext_sel_i   (ext_sel_i),
  .hs_en_i     (hs_en_i),
  .cts_i       (cts_i),
  .wr_en_i     (wr_en_i),
  .tick_i      (bit_tick),
  .busy_i      (busy),
  .txd_o       (txd_o),
  .sclk_o      (sclk_o),
  .tx_irq_o    (tx_irq_o),
  .buf_empty_o (buf_empty_o)
);

// File: tb/ser_tx_top_tb_top.sv
module ser_tx_top_tb_top;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       base_en = 1'b0, wr_en = 1'b0, io_mode = 1'b0;
  logic [8:0] wr_data = '0;
  logic [1:0] fmt = '0;
  logic       hs_en = 1'b0, cts = 1'b0, ext_sel = 1'b0, ext_clk = 1'b0, ext_fall = 1'b0;
  logic       txd, sclk, irq, empty;
  int         checks = 0, fails = 0, ec = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  ser_tx_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .base_en_i(base_en), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .io_mode_i(io_mode), .fmt_i(fmt), .hs_en_i(hs_en),
    .cts_i(cts), .ext_sel_i(ext_sel), .ext_clk_i(ext_clk), .ext_fall_i(ext_fall),
    .txd_o(txd), .sclk_o(sclk), .tx_irq_o(irq), .buf_empty_o(empty)
  );

  initial forever begin
    @(negedge clk);
    base_en = ~base_en;
  end

  // base enables counted since reset
  always @(posedge clk or negedge rst_n)
    if (!rst_n) ec <= 0;
    else if (base_en) ec <= ec + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_word(input logic [8:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic int nbits(input int f);
    case (f)
      0: return 9;
      1: return 10;
      default: return 11;
    endcase
  endfunction

  function automatic logic [11:0] exp_frame(input int f, input logic [8:0] d);
    case (f)
      0: return {3'b111, 1'b1, d[6:0], 1'b0};
      1: return {2'b11, 1'b1, d[7:0], 1'b0};
      2: return {1'b1, 1'b1, ^d[7:0], d[7:0], 1'b0};
      default: return {1'b1, 1'b1, d, 1'b0};
    endcase
  endfunction

  // entered on the first negedge of the start bit; samples first and last cycle of each bit
  task automatic rx_frame(input int n, output logic [11:0] a, output logic [11:0] b);
    a = '1; b = '1;
    for (int i = 0; i < n; i++) begin
      a[i] = txd;
      wait_n(31);
      b[i] = txd;
      wait_n(1);
    end
  endtask

  // wait for start bit; checks tick alignment relative to enable count e0
  task automatic wait_start(input int e0, input string req);
    int lim = 0;
    while (txd !== 1'b0 && lim < 2000) begin
      @(negedge clk);
      lim++;
    end
    check((ec % 16 == 0) && (ec - e0 > 0) && (ec - e0 <= 16), req, ec - e0, 16);
  endtask

  task automatic send_check(input int f, input logic [8:0] d);
    logic [11:0] a, b, e;
    int e0;
    fmt = 2'(f);
    write_word(d);
    e0 = ec;
    wait_start(e0, "R3/R8 start at next bit step");
    check(irq === 1'b1, "R9 irq on handoff", int'(irq), 1);
    check(empty === 1'b1, "R6 empty after handoff", int'(empty), 1);
    rx_frame(nbits(f), a, b);
    e = exp_frame(f, d);
    check(a == e, (f == 2) ? "R4/R5 frame bits with parity" : "R4 frame bits", int'(a), int'(e));
    check(b == e, "R2 bit held 16 enables", int'(b), int'(e));
    check(txd === 1'b1, "R4 idle high after stop", int'(txd), 1);
  endtask

  task automatic io_int_check(input logic [8:0] d);
    logic [7:0] got = '0;
    int rises = 0;
    logic prev = 1'b0;
    write_word(d);
    for (int k = 0; k < 500; k++) begin
      @(negedge clk);
      if (sclk && !prev) begin
        if (rises < 8) got[rises] = txd;
        rises++;
      end
      prev = sclk;
    end
    check(rises == 8, "R10 sclk rise count", rises, 8);
    check(got == d[7:0], "R10 shifted bits LSB first", int'(got), int'(d[7:0]));
    check(txd === 1'b1 && sclk === 1'b0, "R10 idle after byte", int'({txd, sclk}), 2);
  endtask

  task automatic io_ext_check(input logic fall, input logic [7:0] d);
    int sel = 0, bad = 0;
    logic e;
    ext_fall = fall;
    write_word({1'b0, d});
    for (int k = 0; k < 18; k++) begin
      wait_n(10);
      ext_clk = ~ext_clk;
      if (ext_clk != fall) sel++;
      wait_n(9);
      e = (sel == 0 || sel > 8) ? 1'b1 : d[sel-1];
      if (txd !== e || sclk !== 1'b0) bad++;
    end
    check(bad == 0, fall ? "R11 falling-edge shift" : "R11 rising-edge shift", bad, 0);
  endtask

  initial begin
    logic [11:0] a, b, e;
    logic [8:0] pats [6] = '{9'h000, 9'h1FF, 9'h0A5, 9'h15A, 9'h101, 9'h0FE};
    int e0, bad;
    wait_n(3);
    check(txd === 1'b1 && sclk === 1'b0 && irq === 1'b0 && empty === 1'b1,
          "R1 reset outputs", int'({txd, sclk, irq, empty}), 4'b1001);
    rst_n = 1'b1;
    wait_n(2);
    check(txd === 1'b1 && empty === 1'b1, "R1 after release", int'({txd, empty}), 3);

    // format sweep, flow control disabled while cts is high (R8)
    hs_en = 1'b0; cts = 1'b1;
    for (int f = 0; f < 4; f++)
      foreach (pats[p]) send_check(f, pats[p]);

    // back-to-back frames R6
    cts = 1'b0; fmt = 2'd1;
    write_word(9'h0C3);
    wait_start(ec, "R3 first of pair");
    fork
      rx_frame(10, a, b);
      begin
        wait_n(40);
        write_word(9'h03C);
        check(empty === 1'b0, "R6 write fills buffer", int'(empty), 0);
      end
    join
    e = exp_frame(1, 9'h0C3);
    check(a == e && b == e, "R6 first frame intact", int'(a), int'(e));
    check(txd === 1'b0 && irq === 1'b1, "R6 next start right after stop", int'({txd, irq}), 1);
    rx_frame(10, a, b);
    e = exp_frame(1, 9'h03C);
    check(a == e && b == e, "R6 second frame", int'(a), int'(e));

    // flow control R7 / R9
    hs_en = 1'b1; cts = 1'b0;
    write_word(9'h05A);
    wait_start(ec, "R7 start while clear");
    fork
      rx_frame(10, a, b);
      begin wait_n(20); cts = 1'b1; end
    join
    e = exp_frame(1, 9'h05A);
    check(a == e && b == e, "R7 frame in progress completes", int'(a), int'(e));
    check(irq === 1'b1, "R9 stall irq", int'(irq), 1);
    check(txd === 1'b1, "R7 line idle at stall", int'(txd), 1);
    write_word(9'h1A6);
    check(empty === 1'b0, "R7 word held in buffer", int'(empty), 0);
    bad = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (txd !== 1'b1) bad++;
    end
    check(bad == 0, "R7 no start while cts high", bad, 0);
    cts = 1'b0;
    e0 = ec;
    wait_start(e0, "R7 resume at next bit step");
    rx_frame(10, a, b);
    e = exp_frame(1, 9'h1A6);
    check(a == e && b == e, "R7 held frame sent", int'(a), int'(e));
    hs_en = 1'b0;

    // shift mode, internal clock R10
    io_mode = 1'b1; ext_sel = 1'b0;
    foreach (pats[p]) io_int_check(pats[p]);

    // shift mode, external clock R11
    ext_sel = 1'b1;
    io_ext_check(1'b0, 8'hA5);
    io_ext_check(1'b0, 8'h3C);
    io_ext_check(1'b1, 8'h5A);
    io_ext_check(1'b1, 8'hC3);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule